// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Set

This block holds the software-visible control state for a two-channel (parameterisable) bus-mastering disk DMA engine. A simple byte-addressed register bus reaches each channel's command byte, status byte and descriptor-table pointer with 1, 2 or 4 byte accesses. The block does not move data. It turns edges of the command start bit into one-cycle start and abort pulses for an external transfer engine, and it hands that engine the descriptor pointer on every start. The engine answers with a completion strobe and, when a transfer goes wrong, a fault strobe.

The status byte mixes three kinds of bit. The active bit is read-only. The fault and interrupt bits are set by hardware and cleared by writing one. The remaining bits, which include the two DMA-capable bits that come out of reset as 1, hold whatever software writes. A single interrupt output is raised while any channel has its interrupt bit set. Writes of the wrong size, and start requests on a channel with no device attached, raise a one-cycle error pulse. Reads return the stored bytes one cycle after the request.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every status byte reads 0x60 (DMA-capable bits 5 and 6 set), every command byte and descriptor pointer reads 0, and irq is low.
- R2: Channel c occupies bytes 8c to 8c+7: command at +0, status at +2, pointer at +4 (little-endian). Bytes +1 and +3 read 0. Access size code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. A read returns the addressed bytes on rdata, lane 0 first, one cycle after rd_en, with rvalid high.
- R3: A single-byte command write that takes bit 0 (start) from 0 to 1 on a channel with its device present sets status bit 0 (active). It also gives a one-cycle dma_start pulse for that channel, with the channel's current pointer on its start_ptr slice.
- R4: A command write that takes start from 1 to 0 clears active and gives a one-cycle dma_abort pulse.
- R5: A start request on a channel whose dev_present bit is low pulses err. It gives no dma_start, leaves active at 0 and stores the start bit as 0.
- R6: Status writes never change the active bit.
- R7: Status bits 1 (fault) and 2 (interrupt) clear when written with 1 and are unchanged when written with 0. A dma_fault strobe sets bit 1.
- R8: A dma_done strobe clears the start bit and the active bit, and sets the interrupt bit of that channel.
- R9: The pointer takes only 4-byte writes at offset +4 and always stores bits 1:0 as 0. A pointer write of another size pulses err and changes nothing.
- R10: Command and status writes of any size other than one byte pulse err and change nothing.
- R11: While bm_en is low, writes have no effect: no register change, no pulse, no err. Reads still return data.
- R12: irq is high exactly while at least one channel's interrupt bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bm_en | input | 1 | Bus-master enable; gates all writes |
| dev_present | input | NUM_CH | Device attached, one bit per channel |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | ADDR_W | Byte address |
| sz | input | 2 | Access size code (0:1, 1:2, 2:4 bytes) |
| wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| dma_done | input | NUM_CH | Transfer-complete strobes from the engine |
| dma_fault | input | NUM_CH | Transfer-fault strobes from the engine |
| dma_start | output | NUM_CH | One-cycle start pulses |
| dma_abort | output | NUM_CH | One-cycle abort pulses |
| start_ptr | output | NUM_CH*PTR_W | Pointer captured at each channel's last start |
| err | output | 1 | One-cycle error pulse |
| irq | output | 1 | Interrupt pending |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | Read data valid |

## Verification
The hardest states to reach are the ones where the interrupt bit stands set while the start bit has already been cleared by hardware, and a later status write must then clear only that bit while active and the capability bits survive. The stimulus reaches this state through the ports alone. It first loads a pointer, raises start with the device present, then fires a completion strobe. It then writes status bytes that carry zeros and ones in the write-one-to-clear positions and reads the byte back through the scoreboard after each step. The refused start and the gated writes are checked the same way: the bench watches for the absence of pulses in the cycle after the write, and the following read shows that the stored bytes are untouched.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
   localparam int CH_BYTES = 8;
   localparam logic [2:0] OFS_CMD = 3'd0;
   localparam logic [2:0] OFS_STS = 3'd2;
   localparam logic [2:0] OFS_PTR = 3'd4;
   localparam int CMD_GO  = 0;
   localparam int STS_ACT = 0;
   localparam int STS_FLT = 1;
   localparam int STS_IRQ = 2;
   localparam logic [7:0] STS_RST = 8'h60;
   localparam logic [1:0] SZ_B = 2'd0;
   localparam logic [1:0] SZ_H = 2'd1;
   localparam logic [1:0] SZ_W = 2'd2;
endpackage

// File: rtl/dmar_wr_decode.sv
module dmar_wr_decode
   import dmar_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input  logic              wr_en,
   input  logic              bm_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        sz,
   output logic [NUM_CH-1:0] cmd_we,
   output logic [NUM_CH-1:0] sts_we,
   output logic [NUM_CH-1:0] ptr_we,
   output logic              size_err
);
   localparam int CH_W = ADDR_W - 3;

   logic [CH_W-1:0] ch;
   logic [2:0]      ofs;

   assign ch  = addr[ADDR_W-1:3];
   assign ofs = addr[2:0];

   always_comb begin
      cmd_we   = '0;
      sts_we   = '0;
      ptr_we   = '0;
      size_err = 1'b0;
      if (wr_en && bm_en && (int'(ch) < NUM_CH)) begin
         case (ofs)
            OFS_CMD: if (sz == SZ_B) cmd_we[ch] = 1'b1; else size_err = 1'b1;
            OFS_STS: if (sz == SZ_B) sts_we[ch] = 1'b1; else size_err = 1'b1;
            OFS_PTR: if (sz == SZ_W) ptr_we[ch] = 1'b1; else size_err = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dmar_chan.sv
module dmar_chan
   import dmar_pkg::*;
#(
   parameter int PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic             sts_we,
   input  logic             ptr_we,
   input  logic [7:0]       wbyte,
   input  logic [PTR_W-3:0] wptr,
   input  logic             dev_ok,
   input  logic             done_i,
   input  logic             fault_i,
   output logic [7:0]       cmd_q,
   output logic [7:0]       sts_q,
   output logic [PTR_W-1:0] ptr_q,
   output logic [PTR_W-1:0] start_ptr_q,
   output logic             start_o,
   output logic             abort_o,
   output logic             refuse_o
);
   logic [7:0]       cmd_n, sts_n;
   logic [PTR_W-1:0] ptr_n;
   logic             go_rise, go_fall;

   assign go_rise = cmd_we && !cmd_q[CMD_GO] &&  wbyte[CMD_GO];
   assign go_fall = cmd_we &&  cmd_q[CMD_GO] && !wbyte[CMD_GO];

   always_comb begin
      cmd_n = cmd_q;
      sts_n = sts_q;
      ptr_n = ptr_q;
      if (sts_we) begin
         sts_n[7:3]     = wbyte[7:3];
         sts_n[STS_IRQ] = sts_q[STS_IRQ] & ~wbyte[STS_IRQ];
         sts_n[STS_FLT] = sts_q[STS_FLT] & ~wbyte[STS_FLT];
      end
      if (fault_i) sts_n[STS_FLT] = 1'b1;
      if (done_i) begin
         cmd_n[CMD_GO]  = 1'b0;
         sts_n[STS_ACT] = 1'b0;
         sts_n[STS_IRQ] = 1'b1;
      end
      if (cmd_we) begin
         cmd_n = wbyte;
         if (go_rise && !dev_ok) cmd_n[CMD_GO] = 1'b0;
         if (go_rise && dev_ok)  sts_n[STS_ACT] = 1'b1;
         if (go_fall)            sts_n[STS_ACT] = 1'b0;
      end
      if (ptr_we) ptr_n = {wptr, 2'b00};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q       <= '0;
         sts_q       <= STS_RST;
         ptr_q       <= '0;
         start_ptr_q <= '0;
         start_o     <= 1'b0;
         abort_o     <= 1'b0;
         refuse_o    <= 1'b0;
      end else begin
         cmd_q    <= cmd_n;
         sts_q    <= sts_n;
         ptr_q    <= ptr_n;
         start_o  <= go_rise && dev_ok;
         abort_o  <= go_fall;
         refuse_o <= go_rise && !dev_ok;
         if (go_rise && dev_ok) start_ptr_q <= ptr_q;
      end
   end

   // R6
   active_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && !done_i && !cmd_we) |=> (sts_q[STS_ACT] == $past(sts_q[STS_ACT])));
   // R3
   start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> sts_q[STS_ACT]);
   // R4
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> !sts_q[STS_ACT]);
   // R8
   done_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !cmd_we) |=> (!sts_q[STS_ACT] && sts_q[STS_IRQ] && !cmd_q[CMD_GO]));
   // R7
   irq_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && wbyte[STS_IRQ] && !done_i) |=> !sts_q[STS_IRQ]);
   // R5
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refuse_o |-> (!start_o && !cmd_q[CMD_GO]));
endmodule

// File: rtl/dmar_rd_mux.sv
module dmar_rd_mux
   import dmar_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int ADDR_W  = 4,
   parameter int PTR_W   = 32,
   parameter bit RD_PIPE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [1:0]              sz,
   input  logic [NUM_CH*8-1:0]     cmd_flat,
   input  logic [NUM_CH*8-1:0]     sts_flat,
   input  logic [NUM_CH*PTR_W-1:0] ptr_flat,
   output logic [31:0]             rdata,
   output logic                    rvalid
);
   localparam int NBYTES = NUM_CH * CH_BYTES;

   logic [7:0]  img [NBYTES];
   logic [31:0] rd_comb;
   int          nb;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_img
      logic [31:0] pw;
      always_comb begin
         pw = '0;
         pw[PTR_W-1:0] = ptr_flat[c*PTR_W +: PTR_W];
      end
      assign img[c*CH_BYTES+0] = cmd_flat[c*8 +: 8];
      assign img[c*CH_BYTES+1] = 8'h00;
      assign img[c*CH_BYTES+2] = sts_flat[c*8 +: 8];
      assign img[c*CH_BYTES+3] = 8'h00;
      for (genvar b = 0; b < 4; b++) begin : g_pb
         assign img[c*CH_BYTES+4+b] = pw[b*8 +: 8];
      end
   end

   always_comb begin
      case (sz)
         SZ_B:    nb = 1;
         SZ_H:    nb = 2;
         default: nb = 4;
      endcase
      rd_comb = '0;
      for (int i = 0; i < 4; i++) begin
         if (i < nb && int'(ADDR_W'(addr + ADDR_W'(i))) < NBYTES)
            rd_comb[i*8 +: 8] = img[ADDR_W'(addr + ADDR_W'(i))];
      end
   end

   if (RD_PIPE) begin : g_pipe
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
         end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_comb;
         end
      end
   end else begin : g_flow
      assign rdata  = rd_comb;
      assign rvalid = rd_en;
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dmar_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int PTR_W   = 32,
   parameter bit RD_PIPE = 1'b1,
   localparam int ADDR_W = $clog2(NUM_CH * CH_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bm_en,
   input  logic [NUM_CH-1:0]       dev_present,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [1:0]              sz,
   input  logic [31:0]             wdata,
   input  logic [NUM_CH-1:0]       dma_done,
   input  logic [NUM_CH-1:0]       dma_fault,
   output logic [NUM_CH-1:0]       dma_start,
   output logic [NUM_CH-1:0]       dma_abort,
   output logic [NUM_CH*PTR_W-1:0] start_ptr,
   output logic                    err,
   output logic                    irq,
   output logic [31:0]             rdata,
   output logic                    rvalid
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("dma_chan_regs: NUM_CH must be 2 or more");
   end
   if (PTR_W < 3 || PTR_W > 32) begin : g_bad_ptr
      $error("dma_chan_regs: PTR_W must lie in 3..32");
   end

   logic [NUM_CH-1:0]       cmd_we, sts_we, ptr_we, refuse, irq_bits;
   logic [NUM_CH*8-1:0]     cmd_flat, sts_flat;
   logic [NUM_CH*PTR_W-1:0] ptr_flat;
   logic                    size_err, size_err_q;

   dmar_wr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .wr_en(wr_en), .bm_en(bm_en), .addr(addr), .sz(sz),
      .cmd_we(cmd_we), .sts_we(sts_we), .ptr_we(ptr_we), .size_err(size_err)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmar_chan #(.PTR_W(PTR_W)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .cmd_we(cmd_we[c]), .sts_we(sts_we[c]), .ptr_we(ptr_we[c]),
         .wbyte(wdata[7:0]), .wptr(wdata[PTR_W-1:2]),
         .dev_ok(dev_present[c]), .done_i(dma_done[c]), .fault_i(dma_fault[c]),
         .cmd_q(cmd_flat[c*8 +: 8]), .sts_q(sts_flat[c*8 +: 8]),
         .ptr_q(ptr_flat[c*PTR_W +: PTR_W]),
         .start_ptr_q(start_ptr[c*PTR_W +: PTR_W]),
         .start_o(dma_start[c]), .abort_o(dma_abort[c]), .refuse_o(refuse[c])
      );
      assign irq_bits[c] = sts_flat[c*8 + STS_IRQ];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) size_err_q <= 1'b0;
      else        size_err_q <= size_err;
   end

   assign err = size_err_q | (|refuse);
   assign irq = |irq_bits;

   dmar_rd_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .RD_PIPE(RD_PIPE)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .sz(sz),
      .cmd_flat(cmd_flat), .sts_flat(sts_flat), .ptr_flat(ptr_flat),
      .rdata(rdata), .rvalid(rvalid)
   );

   // R10
   cmd_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bm_en && addr[2:0] == OFS_CMD && sz != SZ_B
       && int'(addr[ADDR_W-1:3]) < NUM_CH) |=> err);
   // R11
   bm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !bm_en) |=> (dma_start == '0 && dma_abort == '0 && !err));
   // R12
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|dma_done));
   // R4
   start_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_start & dma_abort) == '0);
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bm_en = 1'b1;
   logic [1:0]  dev_present = 2'b11;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [1:0]  sz = '0;
   logic [31:0] wdata = '0;
   logic [1:0]  dma_done = '0, dma_fault = '0;
   logic [1:0]  dma_start, dma_abort;
   logic [63:0] start_ptr;
   logic        err, irq;
   logic [31:0] rdata;
   logic        rvalid;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [1:0]  s_start, s_abort;
   logic        s_err;
   logic [63:0] s_ptr;

   always #10 clk = ~clk;

   dma_chan_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bm_en(bm_en), .dev_present(dev_present),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .sz(sz), .wdata(wdata),
      .dma_done(dma_done), .dma_fault(dma_fault), .dma_start(dma_start),
      .dma_abort(dma_abort), .start_ptr(start_ptr), .err(err), .irq(irq),
      .rdata(rdata), .rvalid(rvalid)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; sz = s; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      s_start = dma_start; s_abort = dma_abort; s_err = err; s_ptr = start_ptr;
   endtask

   task automatic rd(logic [3:0] a, logic [1:0] s, logic [31:0] exp, string tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a; sz = s;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic strobe_done(logic [1:0] m);
      @(negedge clk); dma_done = m;
      @(negedge clk); dma_done = '0;
   endtask

   task automatic strobe_fault(logic [1:0] m);
      @(negedge clk); dma_fault = m;
      @(negedge clk); dma_fault = '0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         if (exp_q.size() == 0) chk("scoreboard underflow", 64'(rdata), 64'hx);
         else chk(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq after reset", 64'(irq), 64'd0);
      rd(4'd2,  2'd0, 32'h60, "R1 ch0 status reset");
      rd(4'd10, 2'd0, 32'h60, "R1 ch1 status reset");
      rd(4'd0,  2'd2, 32'h0060_0000, "R2 ch0 word at 0 with reserved bytes");
      rd(4'd4,  2'd2, 32'h0, "R1 ch0 pointer reset");
      // R9 pointer alignment and size
      wr(4'd4, 2'd2, 32'h1234_5677);
      chk("R9 aligned pointer write no err", 64'(s_err), 64'd0);
      rd(4'd4, 2'd2, 32'h1234_5674, "R9 pointer low bits zero");
      wr(4'd4, 2'd1, 32'h0000_FFFF);
      chk("R9 half pointer write err", 64'(s_err), 64'd1);
      rd(4'd4, 2'd2, 32'h1234_5674, "R9 pointer unchanged");
      rd(4'd6, 2'd1, 32'h1234, "R2 upper pointer half");
      // R3 start
      wr(4'd0, 2'd0, 32'h09);
      chk("R3 start pulse", 64'(s_start), 64'd1);
      chk("R3 start pointer", s_ptr[31:0], 64'h1234_5674);
      chk("R3 no err", 64'(s_err), 64'd0);
      rd(4'd2, 2'd0, 32'h61, "R3 active set");
      rd(4'd0, 2'd0, 32'h09, "R3 command stored");
      // R6 active read-only
      wr(4'd2, 2'd0, 32'h00);
      rd(4'd2, 2'd0, 32'h01, "R6 active kept, caps cleared");
      wr(4'd2, 2'd0, 32'h60);
      rd(4'd2, 2'd0, 32'h61, "R6 caps restored");
      // R8 completion
      strobe_done(2'b01);
      chk("R12 irq after done", 64'(irq), 64'd1);
      rd(4'd2, 2'd0, 32'h64, "R8 active cleared int set");
      rd(4'd0, 2'd0, 32'h08, "R8 start bit cleared");
      // R7 write one to clear
      wr(4'd2, 2'd0, 32'h60);
      rd(4'd2, 2'd0, 32'h64, "R7 zero leaves int");
      wr(4'd2, 2'd0, 32'h64);
      rd(4'd2, 2'd0, 32'h60, "R7 one clears int");
      chk("R12 irq cleared", 64'(irq), 64'd0);
      strobe_fault(2'b01);
      rd(4'd2, 2'd0, 32'h62, "R7 fault sets bit1");
      wr(4'd2, 2'd0, 32'h62);
      rd(4'd2, 2'd0, 32'h60, "R7 fault cleared");
      // R4 abort
      wr(4'd0, 2'd0, 32'h01);
      chk("R4 restart pulse", 64'(s_start), 64'd1);
      wr(4'd0, 2'd0, 32'h00);
      chk("R4 abort pulse", 64'(s_abort), 64'd1);
      chk("R4 no start on stop", 64'(s_start), 64'd0);
      rd(4'd2, 2'd0, 32'h60, "R4 active cleared");
      // R5 no device
      dev_present = 2'b01;
      wr(4'd8, 2'd0, 32'h01);
      chk("R5 err on refused start", 64'(s_err), 64'd1);
      chk("R5 no start pulse", 64'(s_start), 64'd0);
      rd(4'd8,  2'd0, 32'h00, "R5 start bit stored 0");
      rd(4'd10, 2'd0, 32'h60, "R5 active stays 0");
      dev_present = 2'b11;
      // R10 size errors
      wr(4'd0, 2'd1, 32'h0001);
      chk("R10 half command err", 64'(s_err), 64'd1);
      chk("R10 no start", 64'(s_start), 64'd0);
      rd(4'd0, 2'd0, 32'h00, "R10 command unchanged");
      wr(4'd2, 2'd2, 32'h0000_0000);
      chk("R10 word status err", 64'(s_err), 64'd1);
      rd(4'd2, 2'd0, 32'h60, "R10 status unchanged");
      // R11 bus-master gate
      bm_en = 1'b0;
      wr(4'd0, 2'd0, 32'h01);
      chk("R11 no start when gated", 64'(s_start), 64'd0);
      chk("R11 no err when gated", 64'(s_err), 64'd0);
      wr(4'd12, 2'd2, 32'hDEAD_BEEC);
      rd(4'd0,  2'd0, 32'h00, "R11 command unchanged, read works");
      rd(4'd12, 2'd2, 32'h0, "R11 pointer unchanged");
      bm_en = 1'b1;
      // channel 1 path, R12 OR of both
      wr(4'd12, 2'd2, 32'hABCD_0003);
      wr(4'd8, 2'd0, 32'h01);
      chk("R3 ch1 start pulse", 64'(s_start), 64'd2);
      chk("R3 ch1 start pointer", s_ptr[63:32], 64'hABCD_0000);
      strobe_done(2'b10);
      chk("R12 irq from ch1", 64'(irq), 64'd1);
      strobe_done(2'b01);
      wr(4'd10, 2'd0, 32'h04);
      chk("R12 irq held by ch0", 64'(irq), 64'd1);
      wr(4'd2, 2'd0, 32'h04);
      chk("R12 irq low when both clear", 64'(irq), 64'd0);
      repeat (3) @(negedge clk);
      chk("scoreboard drained", 64'(exp_q.size()), 64'd0);
      finished = 1'b1;
      summary();
   end
endmodule